// File: doc/BRIEF.md
# Boot Image Loader with Secure-Failure RAM Wipe

This controller runs once after reset. It pulls a boot image out of a ROM that has no address input: the ROM shows one word at a time and steps to the following word whenever the controller pulses a request line. Each word is written into the shared RAM. The first word goes to byte address 0 and each later word goes 4 bytes higher. With the default sizes the image is 4096 words of 32 bits, which fills the low 16 KB of the RAM.

When the last word has been written, the controller lets core 0 out of reset so that it can run the loaded image. From then on the controller watches a security-enable input and a secure-failure input. A failure that arrives while security is enabled holds core 0 in reset again. The controller then writes zero to every word of the RAM, one word per cycle from the bottom up, and finally raises a sticky halt flag. When security is disabled the failure input has no effect and the RAM is never cleared. The hashing logic that produces the failure report lies outside this block.

Top module: `boot_copy_clear_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `ram_we`, `rom_next`, `core0_run` and `halted` are all 0.
- R2: After reset is released, `rom_next` is high for exactly COPY_WORDS cycles, one request per copied word, and it is never high once core 0 has been released.
- R3: The k-th RAM write of the copy (k = 0 .. COPY_WORDS-1) carries the k-th ROM word at byte address 4*k. The writes fall on consecutive cycles.
- R4: `core0_run` rises in the cycle after the cycle that shows the final copy write, and never earlier.
- R5: `ram_we` is never high while `core0_run` is high.
- R6: If `sec_en` and `sec_fail` are both 1 on a clock edge while core 0 is running, `core0_run` is 0 from the next cycle on. RAM_WORDS writes of value 0 follow, at byte addresses 0, 4, ..., 4*(RAM_WORDS-1).
- R7: After the clear, `halted` goes to 1 and stays at 1 until reset. No more writes occur and `core0_run` stays 0.
- R8: While `sec_en` is 0, `sec_fail` is ignored: `core0_run` stays 1, no RAM write occurs and `halted` stays 0.
- R9: A `sec_fail` that arrives before core 0 is released is ignored. The copy completes unchanged and core 0 is released.
- R10: Inside each of the two walks, consecutive writes step the byte address by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_data | input | DATA_W | Word the ROM presents at its current position |
| rom_next | output | 1 | Request that moves the ROM to its next word at the clock edge |
| sec_en | input | 1 | Security enabled |
| sec_fail | input | 1 | Secure startup reports failure |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM byte address, always a multiple of 4 |
| ram_wdata | output | DATA_W | RAM write data |
| core0_run | output | 1 | Releases core 0 from reset when high |
| halted | output | 1 | Wipe finished; stays high until reset |

## Verification
The checks take for granted that the ROM moves to its next word on the same clock edge that samples `rom_next` high, and that `sec_en` and `sec_fail` are synchronous to `clk`. The reason-for-drop property treats only a sampled pair `sec_en`/`sec_fail`, or reset, as a legal cause for `core0_run` to fall. The bench models the ROM with a pointer that advances on exactly those edges. It drives every input two nanoseconds after a rising edge. Random failure pulses are applied during the copy, or during the run while security is off, so each one lands in a window where the requirements say it must be ignored. A single failure is placed deliberately when a wipe is wanted.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COPY    = 3'd1,
    ST_RELEASE = 3'd2,
    ST_RUN     = 3'd3,
    ST_CLEAR   = 3'd4,
    ST_HALT    = 3'd5
  } boot_state_e;

endpackage

// File: rtl/boot_ld_walk_cnt.sv
// Word index shared by the copy walk and the wipe walk.
module boot_ld_walk_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/boot_ld_fsm.sv
// Sequencer: IDLE -> COPY -> RELEASE -> RUN, then RUN -> CLEAR -> HALT on a secure failure.
module boot_ld_fsm
  import boot_ld_pkg::*;
#(
  parameter int COPY_WORDS = 4096,
  parameter int RAM_WORDS  = 131072,
  parameter int CNT_W      = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             sec_en,
  input  logic             sec_fail,
  output boot_state_e      state,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             abort
);

  localparam logic [CNT_W-1:0] COPY_END  = CNT_W'(COPY_WORDS - 1);
  localparam logic [CNT_W-1:0] CLEAR_END = CNT_W'(RAM_WORDS - 1);

  boot_state_e state_nxt;
  logic        copy_last;
  logic        clear_last;

  assign copy_last  = (cnt == COPY_END);
  assign clear_last = (cnt == CLEAR_END);
  assign abort      = (state == ST_RUN) && sec_en && sec_fail;

  always_comb begin
    state_nxt = state;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cnt_clr   = 1'b1;
        state_nxt = ST_COPY;
      end
      ST_COPY: begin
        cnt_inc = 1'b1;
        if (copy_last) state_nxt = ST_RELEASE;
      end
      ST_RELEASE: begin
        cnt_clr   = 1'b1;
        state_nxt = ST_RUN;
      end
      ST_RUN: begin
        cnt_clr = 1'b1;
        if (abort) state_nxt = ST_CLEAR;
      end
      ST_CLEAR: begin
        cnt_inc = 1'b1;
        if (clear_last) state_nxt = ST_HALT;
      end
      ST_HALT: begin
        state_nxt = ST_HALT;
      end
      default: begin
        state_nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

endmodule

// File: rtl/boot_ld_ram_port.sv
// Registered write port and control outputs.
module boot_ld_ram_port
  import boot_ld_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 17,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  boot_state_e       state,
  input  logic              abort,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] rom_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              core0_run,
  output logic              halted
);

  logic copying;
  logic wiping;

  assign copying = (state == ST_COPY);
  assign wiping  = (state == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      core0_run <= 1'b0;
      halted    <= 1'b0;
    end else begin
      ram_we    <= copying || wiping;
      ram_addr  <= {cnt, 2'b00};
      ram_wdata <= copying ? rom_data : '0;
      core0_run <= (state == ST_RELEASE) || ((state == ST_RUN) && !abort);
      halted    <= (state == ST_HALT);
    end
  end

endmodule

// File: rtl/boot_copy_clear_ctrl.sv
module boot_copy_clear_ctrl
  import boot_ld_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COPY_WORDS = 4096,
  parameter int RAM_WORDS  = 131072,
  localparam int CNT_W     = $clog2(RAM_WORDS),
  localparam int ADDR_W    = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rom_next,
  input  logic              sec_en,
  input  logic              sec_fail,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              core0_run,
  output logic              halted
);

  boot_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             abort;

  boot_ld_walk_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  boot_ld_fsm #(
    .COPY_WORDS (COPY_WORDS),
    .RAM_WORDS  (RAM_WORDS),
    .CNT_W      (CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .sec_en   (sec_en),
    .sec_fail (sec_fail),
    .state    (state),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .abort    (abort)
  );

  boot_ld_ram_port #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) i_port (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .abort     (abort),
    .cnt       (cnt),
    .rom_data  (rom_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .core0_run (core0_run),
    .halted    (halted)
  );

  // The ROM request is decoded straight from the state register.
  assign rom_next = (state == ST_COPY);

endmodule

// File: rtl/boot_copy_clear_chk.sv
module boot_copy_clear_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              rom_next,
  input logic              sec_en,
  input logic              sec_fail,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              core0_run,
  input logic              halted
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!ram_we && !rom_next && !core0_run && !halted));

  // R2
  rom_next_pre_release_chk: assert property (@(posedge clk) disable iff (rst)
    rom_next |-> (!core0_run && !halted));

  // R4
  release_after_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core0_run) |-> ($past(ram_we) && !ram_we));

  // R5
  no_write_while_run_chk: assert property (@(posedge clk) disable iff (rst)
    core0_run |-> !ram_we);

  // R6
  run_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(core0_run) && !$past(rst)) |-> $past(sec_en && sec_fail));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !ram_we && !core0_run));

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(4)));

endmodule

bind boot_copy_clear_ctrl boot_copy_clear_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rom_next  (rom_next),
  .sec_en    (sec_en),
  .sec_fail  (sec_fail),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .core0_run (core0_run),
  .halted    (halted)
);

// File: tb/test_boot_copy_clear_ctrl.sv
module test_boot_copy_clear_ctrl;

  localparam int CW = 32;
  localparam int RW = 128;
  localparam int DW = 32;
  localparam int AW = $clog2(RW) + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] rom_data;
  logic          rom_next;
  logic          sec_en = 1'b0;
  logic          sec_fail = 1'b0;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          core0_run;
  logic          halted;

  always #5 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  logic [31:0] rom_seed = '0;
  int          rom_ptr = 0;
  int          wr_idx = 0;
  int          nxt_cnt = 0;
  bit          phase_clear = 1'b0;
  bit          run_seen = 1'b0;

  boot_copy_clear_ctrl #(
    .DATA_W     (DW),
    .COPY_WORDS (CW),
    .RAM_WORDS  (RW)
  ) i_boot_copy_clear_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rom_data  (rom_data),
    .rom_next  (rom_next),
    .sec_en    (sec_en),
    .sec_fail  (sec_fail),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .core0_run (core0_run),
    .halted    (halted)
  );

  function automatic logic [31:0] rom_word(logic [31:0] s, int i);
    logic [31:0] ii;
    ii = 32'(i);
    return (ii * 32'h9E37_79B1) ^ s ^ {ii[15:0], 16'h5A5A};
  endfunction

  assign rom_data = rom_word(rom_seed, rom_ptr);

  always @(posedge clk) begin
    if (rst) rom_ptr <= 0;
    else if (rom_next) rom_ptr <= rom_ptr + 1;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rom_next) begin
        nxt_cnt++;
        check(!run_seen, "R2", "rom_next after release", 64'(rom_next), 64'd0);
      end
      if (ram_we) begin
        check(!core0_run, "R5", "write while core0 released", 64'(core0_run), 64'd0);
        check(ram_addr == AW'(4 * wr_idx), "R10", "address step", 64'(ram_addr), 64'(4 * wr_idx));
        if (!phase_clear) begin
          check(ram_wdata == rom_word(rom_seed, wr_idx), "R3", "copy data",
                64'(ram_wdata), 64'(rom_word(rom_seed, wr_idx)));
        end else begin
          check(ram_wdata == '0, "R6", "wipe data", 64'(ram_wdata), 64'd0);
        end
        wr_idx++;
      end
      if (core0_run && !run_seen) begin
        run_seen = 1'b1;
        check(wr_idx == CW, "R4", "writes before release", 64'(wr_idx), 64'(CW));
      end
    end
  end

  task automatic do_run(logic [31:0] seed, bit sec, bit noisy, bit fail);
    int n;
    @(posedge clk); #2;
    rst = 1'b1; rom_seed = seed; sec_en = sec; sec_fail = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!ram_we && !rom_next && !core0_run && !halted, "R1", "outputs in reset",
          64'({ram_we, rom_next, core0_run, halted}), 64'd0);
    @(posedge clk); #2;
    wr_idx = 0; nxt_cnt = 0; phase_clear = 1'b0; run_seen = 1'b0;
    rst = 1'b0;
    for (int c = 0; c < CW + 4; c++) begin
      @(posedge clk); #2;
      sec_fail = (noisy && c < CW) ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    @(negedge clk);
    check(core0_run, noisy ? "R9" : "R4", "core0 released", 64'(core0_run), 64'd1);
    check(wr_idx == CW, "R3", "copy write count", 64'(wr_idx), 64'(CW));
    check(nxt_cnt == CW, "R2", "ROM request count", 64'(nxt_cnt), 64'(CW));
    n = $urandom_range(8, 30);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #2;
      sec_fail = !sec ? 1'($urandom_range(0, 1)) : 1'b0;
    end
    @(posedge clk); #2; sec_fail = 1'b0;
    @(negedge clk);
    check(core0_run && !halted && wr_idx == CW, sec ? "R4" : "R8", "still running",
          64'({core0_run, halted}), 64'b10);
    if (fail) begin
      @(posedge clk); #2;
      phase_clear = 1'b1; wr_idx = 0; sec_fail = 1'b1;
      @(posedge clk); #2; sec_fail = 1'b0;
      @(negedge clk);
      check(core0_run == !sec, sec ? "R6" : "R8", "core0 after failure", 64'(core0_run), 64'(!sec));
      repeat (RW + 4) @(posedge clk);
      @(negedge clk);
      check(wr_idx == (sec ? RW : 0), sec ? "R6" : "R8", "wipe write count",
            64'(wr_idx), 64'(sec ? RW : 0));
      check(halted == sec, sec ? "R7" : "R8", "halt flag", 64'(halted), 64'(sec));
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(wr_idx == (sec ? RW : 0) && halted == sec && core0_run == !sec, "R7", "final state",
            64'({halted, core0_run}), 64'({sec, !sec}));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_run(32'h1234_5678, 1'b0, 1'b0, 1'b1);
    do_run(32'hCAFE_0001, 1'b1, 1'b1, 1'b1);
    do_run(32'h0F0F_F0F0, 1'b1, 1'b0, 1'b0);
    for (int r = 0; r < 4; r++) begin
      do_run($urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule